// File: doc/BRIEF.md
# Receive-Enable Delay Calibration Sequencer

This block trains the receive-enable delay of one memory channel, one byte lane after another. It drives a delay setting that has three nested levels: a coarse count of whole clock periods, a medium quarter step and a fine tap. It also drives a small phase-interpolator code. For every probe of the strobe it pulses the strobe sampler's reset, asks for a read, and waits for the sampled strobe level to come back. It uses these levels to find the strobe low region, then the rising edge, then the real preamble one or more periods earlier, and it finishes on the rising edge at fine resolution.

Once every lane has been trained, the block finds the smallest coarse value in the channel. It programs that value into the shared coarse field and reports a 2-bit coarse offset for each lane. A failure aborts the run. It raises a sticky fail flag that carries the lane index. Done pulses once at the end of every run, whether the run passed or failed. The delay lines and the memory device sit outside the block.

Top module: `rcven_cal`

## Requirements
- R1: After reset, `done`, `fail`, `rd_req` and `rcv_en` are 0 and `probe_rst_n` is 1.
- R2: The delay is mixed-radix. Tap runs 0..14 and carries into medium. Medium runs 0..3 and carries into coarse. Coarse tops out at 15. A tap borrow from 0 gives tap 14 at one medium lower. The linear position is coarse*60 + medium*15 + tap.
- R3: Every lane starts at coarse = `cas_lat`+1, tap 0 and PI 0. Its medium starts at lane/2 (lanes 0-1 get 0, lanes 2-3 get 1, lanes 4-5 get 2, lanes 6-7 get 3). Lanes are trained in order 0 to 7.
- R4: Each probe follows a fixed sequence. `probe_rst_n` is held low for RST_WAIT cycles and then high for RST_WAIT cycles. Then `rd_req` pulses for one cycle. The level is taken from `smp_level` in the cycle when `smp_valid` is 1.
- R5: While a lane is being trained, `rcv_en` has exactly that lane's bit set. When the run ends, `rcv_en` is 0.
- R6: The search runs in six phases:
  1. Step medium up to strobe low, plus one medium.
  2. Step medium up to high.
  3. Go back one medium and step tap up (at least once) to high.
  4. Go back one tap, set PI 3, add one medium and require high.
  5. Decrement coarse until low.
  6. Repeat the medium-up, back-one and tap-up search, then go back one tap and set PI 7.
  On a strobe that is low before its first rising edge, this leaves each lane one tap before that edge.
- R7: At the end, `dly_coarse` equals the minimum lane coarse. Each lane's 2-bit field in `coarse_ofs` (lane i at bits 2i+1:2i) holds the low two bits of its coarse minus that minimum, or 0 if its coarse is 0.
- R8: A medium step past medium 3 at coarse 15, or back past medium 0 at coarse 0, fails the run. `fail_lane` then holds the lane being trained.
- R9: If the preamble coarse decrement reaches coarse 0 while the strobe still reads high, or if the strobe is not high after the preamble medium step, the run fails.
- R10: `done` is high for exactly one cycle per run, whether the run passed or failed. `fail` stays high until the next `start`, which clears it. `start` is acted on only when the block is idle.
- R11: The delay outputs have settled for SETTLE_CYC cycles (at least one) before each probe reset begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (acted on only when idle) |
| cas_lat | input | 4 | CAS latency; the starting coarse is this plus 1 |
| smp_valid | input | 1 | The sampled strobe level is valid this cycle |
| smp_level | input | 1 | Sampled strobe level |
| probe_rst_n | output | 1 | Active-low reset of the strobe sampler |
| rd_req | output | 1 | One-cycle read request for a probe |
| rcv_en | output | 8 | Receive-enable bit for each lane |
| lane_sel | output | 3 | Lane currently being trained |
| dly_coarse | output | 4 | Coarse delay (after the run, the channel minimum) |
| dly_medium | output | 2 | Medium delay of the active lane |
| dly_tap | output | 4 | Fine tap of the active lane |
| dly_pi | output | 3 | PI code of the active lane |
| res_medium | output | 16 | Final medium for each lane, 2 bits per lane |
| res_tap | output | 32 | Final tap for each lane, 4 bits per lane |
| coarse_ofs | output | 16 | Coarse offset for each lane, 2 bits per lane |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky failure flag |
| fail_lane | output | 3 | Lane on which the failure occurred |

## Verification
A delay change becomes visible on the next edge. After that, `probe_rst_n` falls SETTLE_CYC cycles later, and `rd_req` rises 2*RST_WAIT cycles after that fall. The bench's sampler model therefore reads the delay outputs on the falling edge where `rd_req` is seen, and it returns `smp_valid` a fixed two cycles later. A lane's `res_medium` and `res_tap` fields are written on the edge that consumes its final sample. `coarse_ofs`, `dly_coarse` and `done` follow one edge after the last lane's final sample; on a failure, `done` and `fail` come on the edge of the failing sample. The bench waits for `done` on falling edges, checks results in that same half cycle, and counts `done` pulses over three further cycles.

// File: rtl/rcven_cal.sv
module rcven_cal #(
  parameter int LANES      = 8,
  parameter int TAP_MAX    = 14,
  parameter int MED_MAX    = 3,
  parameter int COARSE_MAX = 15,
  parameter int SETTLE_CYC = 2,
  parameter int RST_WAIT   = 3,
  localparam int LW = $clog2(LANES),
  localparam int CW = $clog2(COARSE_MAX + 1),
  localparam int MW = $clog2(MED_MAX + 1),
  localparam int TW = $clog2(TAP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    cas_lat,
  input  logic             smp_valid,
  input  logic             smp_level,
  output logic             probe_rst_n,
  output logic             rd_req,
  output logic [LANES-1:0] rcv_en,
  output logic [LW-1:0]    lane_sel,
  output logic [CW-1:0]    dly_coarse,
  output logic [MW-1:0]    dly_medium,
  output logic [TW-1:0]    dly_tap,
  output logic [2:0]       dly_pi,
  output logic [MW*LANES-1:0] res_medium,
  output logic [TW*LANES-1:0] res_tap,
  output logic [2*LANES-1:0]  coarse_ofs,
  output logic             done,
  output logic             fail,
  output logic [LW-1:0]    fail_lane
);
  localparam int CMAXV = (SETTLE_CYC > RST_WAIT) ? SETTLE_CYC : RST_WAIT;
  localparam int CNTW  = $clog2(CMAXV + 1);

  typedef struct packed {
    logic          err;
    logic [CW-1:0] c;
    logic [MW-1:0] m;
    logic [TW-1:0] t;
  } dly_t;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_PLO, S_PHI, S_PRD, S_PWT, S_NORM} st_t;
  typedef enum logic [2:0] {PH_LOW, PH_HIGH1, PH_FINE1, PH_VERIFY, PH_CDEC, PH_HIGH2, PH_FINE2} ph_t;

  st_t st;
  ph_t ph, nph;
  logic [CNTW-1:0] cnt;
  logic [LW-1:0]   lane;
  logic [CW-1:0]   cur_c, mn;
  logic [MW-1:0]   cur_m;
  logic [TW-1:0]   cur_t;
  logic [2:0]      pi, npi;
  logic [CW-1:0]   lc [LANES];
  logic [2*LANES-1:0] ofs_n;
  dly_t cur, nd;
  logic fin;

  function automatic dly_t inc_med(dly_t d);
    dly_t r = d;
    if (d.m < MW'(MED_MAX)) r.m = d.m + 1'b1;
    else if (d.c < CW'(COARSE_MAX)) begin r.m = '0; r.c = d.c + 1'b1; end
    else r.err = 1'b1;
    return r;
  endfunction

  function automatic dly_t dec_med(dly_t d);
    dly_t r = d;
    if (d.m != '0) r.m = d.m - 1'b1;
    else if (d.c != '0) begin r.m = MW'(MED_MAX); r.c = d.c - 1'b1; end
    else r.err = 1'b1;
    return r;
  endfunction

  function automatic dly_t inc_tap(dly_t d);
    dly_t r = d;
    if (d.t == TW'(TAP_MAX)) begin r = inc_med(d); r.t = '0; end
    else r.t = d.t + 1'b1;
    return r;
  endfunction

  function automatic dly_t dec_tap(dly_t d);
    dly_t r = d;
    if (d.t != '0) r.t = d.t - 1'b1;
    else begin r = dec_med(d); r.t = TW'(TAP_MAX); end
    return r;
  endfunction

  function automatic logic [MW-1:0] start_med(logic [LW-1:0] l);
    return MW'((int'(l) / 2) % (MED_MAX + 1));
  endfunction

  assign cur = '{err: 1'b0, c: cur_c, m: cur_m, t: cur_t};

  always_comb begin
    nd  = cur;
    nph = ph;
    npi = pi;
    fin = 1'b0;
    unique case (ph)
      PH_LOW: begin
        nd = inc_med(cur);
        if (!smp_level) nph = PH_HIGH1;
      end
      PH_HIGH1, PH_HIGH2: begin
        if (smp_level) begin
          nd  = inc_tap(dec_med(cur));
          nph = (ph == PH_HIGH1) ? PH_FINE1 : PH_FINE2;
        end else nd = inc_med(cur);
      end
      PH_FINE1: begin
        if (smp_level) begin
          nd  = inc_med(dec_tap(cur));
          npi = 3'd3;
          nph = PH_VERIFY;
        end else nd = inc_tap(cur);
      end
      PH_VERIFY, PH_CDEC: begin
        if (!smp_level) begin
          if (ph == PH_VERIFY) nd.err = 1'b1;
          else begin nd = inc_med(cur); nph = PH_HIGH2; end
        end else if (cur_c == '0) nd.err = 1'b1;
        else begin nd.c = cur_c - 1'b1; nph = PH_CDEC; end
      end
      PH_FINE2: begin
        if (smp_level) begin
          nd  = dec_tap(cur);
          npi = 3'd7;
          fin = 1'b1;
        end else nd = inc_tap(cur);
      end
      default: nd.err = 1'b1;
    endcase
  end

  always_comb begin
    mn = '1;
    for (int l = 0; l < LANES; l++)
      if (lc[l] < mn) mn = lc[l];
    for (int l = 0; l < LANES; l++)
      ofs_n[2*l +: 2] = (lc[l] == '0) ? 2'd0 : 2'(lc[l] - mn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_LOW; cnt <= '0; lane <= '0;
      cur_c <= '0; cur_m <= '0; cur_t <= '0; pi <= '0;
      for (int l = 0; l < LANES; l++) lc[l] <= '0;
      res_medium <= '0; res_tap <= '0; coarse_ofs <= '0;
      done <= 1'b0; fail <= 1'b0; fail_lane <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          fail <= 1'b0; fail_lane <= '0; lane <= '0;
          cur_c <= cas_lat + 1'b1; cur_m <= start_med('0); cur_t <= '0; pi <= '0;
          ph <= PH_LOW; cnt <= '0; st <= S_SETTLE;
        end
        S_SETTLE: if (cnt == CNTW'(SETTLE_CYC - 1)) begin cnt <= '0; st <= S_PLO; end
                  else cnt <= cnt + 1'b1;
        S_PLO:    if (cnt == CNTW'(RST_WAIT - 1)) begin cnt <= '0; st <= S_PHI; end
                  else cnt <= cnt + 1'b1;
        S_PHI:    if (cnt == CNTW'(RST_WAIT - 1)) begin cnt <= '0; st <= S_PRD; end
                  else cnt <= cnt + 1'b1;
        S_PRD:    st <= S_PWT;
        S_PWT: if (smp_valid) begin
          cnt <= '0;
          if (nd.err) begin
            fail <= 1'b1; fail_lane <= lane; done <= 1'b1; st <= S_IDLE;
          end else if (fin) begin
            lc[lane] <= nd.c;
            res_medium[int'(lane)*MW +: MW] <= nd.m;
            res_tap[int'(lane)*TW +: TW]    <= nd.t;
            if (lane == LW'(LANES - 1)) begin
              cur_c <= nd.c; cur_m <= nd.m; cur_t <= nd.t; pi <= npi; st <= S_NORM;
            end else begin
              lane <= lane + 1'b1;
              cur_c <= cas_lat + 1'b1; cur_m <= start_med(lane + 1'b1); cur_t <= '0;
              pi <= '0; ph <= PH_LOW; st <= S_SETTLE;
            end
          end else begin
            cur_c <= nd.c; cur_m <= nd.m; cur_t <= nd.t; pi <= npi; ph <= nph;
            st <= S_SETTLE;
          end
        end
        S_NORM: begin
          cur_c <= mn; coarse_ofs <= ofs_n; done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign probe_rst_n = (st != S_PLO);
  assign rd_req      = (st == S_PRD);
  assign rcv_en      = (st != S_IDLE && st != S_NORM) ? (LANES'(1) << lane) : '0;
  assign lane_sel    = lane;
  assign dly_coarse  = cur_c;
  assign dly_medium  = cur_m;
  assign dly_tap     = cur_t;
  assign dly_pi      = pi;
endmodule

// File: rtl/rcven_cal_chk.sv
module rcven_cal_chk #(
  parameter int LANES = 8,
  parameter int TAP_MAX = 14,
  parameter int CW = 4,
  parameter int MW = 2,
  parameter int TW = 4,
  parameter int LW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             probe_rst_n,
  input logic             rd_req,
  input logic [LANES-1:0] rcv_en,
  input logic [LW-1:0]    lane_sel,
  input logic [CW-1:0]    dly_coarse,
  input logic [MW-1:0]    dly_medium,
  input logic [TW-1:0]    dly_tap,
  input logic [2:0]       dly_pi,
  input logic             done,
  input logic             fail
);
  AST_RD_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R4
  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> $past(probe_rst_n)); // R4
  AST_EN_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rcv_en)); // R5
  AST_EN_LANE:     assert property (@(posedge clk) disable iff (!rst_n) (rcv_en != '0) |-> rcv_en[lane_sel]); // R5
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (rcv_en == '0)); // R5
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (fail && !start) |=> fail); // R10
  AST_TAP_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) dly_tap <= TW'(TAP_MAX)); // R2
  AST_SETTLED:     assert property (@(posedge clk) disable iff (!rst_n)
                     $fell(probe_rst_n) |-> $stable({dly_coarse, dly_medium, dly_tap, dly_pi})); // R11
endmodule

bind rcven_cal rcven_cal_chk #(
  .LANES(LANES), .TAP_MAX(TAP_MAX), .CW(CW), .MW(MW), .TW(TW), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .probe_rst_n(probe_rst_n), .rd_req(rd_req),
  .rcv_en(rcv_en), .lane_sel(lane_sel), .dly_coarse(dly_coarse), .dly_medium(dly_medium),
  .dly_tap(dly_tap), .dly_pi(dly_pi), .done(done), .fail(fail)
);

// File: tb/rcven_cal_bench.sv
`timescale 1ns/1ps
module rcven_cal_bench;
  localparam int RW = 3;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] cas_lat = 4'd4;
  logic smp_valid = 1'b0, smp_level = 1'b0;
  logic probe_rst_n, rd_req, done, fail;
  logic [7:0] rcv_en;
  logic [2:0] lane_sel, dly_pi, fail_lane;
  logic [3:0] dly_coarse, dly_tap;
  logic [1:0] dly_medium;
  logic [15:0] res_medium, coarse_ofs;
  logic [31:0] res_tap;

  int n_tests = 0, n_fail = 0;
  int edge_pos [8];
  int cur_cas;
  bit seen [8];
  int done_cnt, proto_bad, rcv_bad;
  int lo_len = 0, hi_len = 0, pend = 0;
  bit prev_rst = 1'b1, lvl_q = 1'b0;

  always #2.5 clk = ~clk;

  rcven_cal u_rcven_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .cas_lat(cas_lat),
    .smp_valid(smp_valid), .smp_level(smp_level), .probe_rst_n(probe_rst_n),
    .rd_req(rd_req), .rcv_en(rcv_en), .lane_sel(lane_sel), .dly_coarse(dly_coarse),
    .dly_medium(dly_medium), .dly_tap(dly_tap), .dly_pi(dly_pi),
    .res_medium(res_medium), .res_tap(res_tap), .coarse_ofs(coarse_ofs),
    .done(done), .fail(fail), .fail_lane(fail_lane)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit strobe(int c, int m, int t, int e);
    int p = c * 60 + m * 15 + t;
    return (p >= e) && (((p - e) % 60) < 30);
  endfunction

  // sampler and strobe model, plus protocol monitor
  always @(negedge clk) begin
    smp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin smp_valid = 1'b1; smp_level = lvl_q; end
    end
    if (done) done_cnt++;
    if (!probe_rst_n) begin
      if (prev_rst) lo_len = 0;
      lo_len++;
      hi_len = 0;
    end else if (rd_req) begin
      if (lo_len != RW || hi_len != RW) proto_bad++;
      if (rcv_en != (8'd1 << lane_sel)) rcv_bad++;
      if (!seen[lane_sel]) begin
        seen[lane_sel] = 1'b1;
        chk(dly_coarse == 4'(cur_cas + 1) && dly_medium == 2'(lane_sel / 2) &&
            dly_tap == 0 && dly_pi == 0, "R3 lane start setting",
            {dly_coarse, dly_medium, dly_tap, dly_pi},
            {4'(cur_cas + 1), 2'(lane_sel / 2), 4'd0, 3'd0});
      end
      lvl_q = strobe(dly_coarse, dly_medium, dly_tap, edge_pos[lane_sel]);
      pend = LAT;
    end else hi_len++;
    prev_rst = probe_rst_n;
  end

  task automatic run_cal(input int cas, input bit exp_fail, input int exp_lane);
    int ec [8];
    int mn;
    for (int l = 0; l < 8; l++) seen[l] = 1'b0;
    done_cnt = 0; proto_bad = 0; rcv_bad = 0; cur_cas = cas;
    @(negedge clk); cas_lat = 4'(cas); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(fail == 1'b0, "R10 fail cleared by start", fail, 0);
    while (!done) @(negedge clk);
    chk(rcv_en == 8'd0, "R5 receive enables clear at end", rcv_en, 0);
    chk(fail == exp_fail, exp_fail ? "R8/R9 fail raised" : "R6 run passes", fail, exp_fail);
    if (exp_fail) begin
      chk(fail_lane == 3'(exp_lane), "R8 failing lane index", fail_lane, exp_lane);
    end else begin
      mn = 99;
      for (int l = 0; l < 8; l++) begin
        int p = edge_pos[l] - 1;
        ec[l] = p / 60;
        if (ec[l] < mn) mn = ec[l];
        chk(res_medium[2*l +: 2] == 2'((p % 60) / 15), "R6 lane medium (R2 radix)",
            res_medium[2*l +: 2], (p % 60) / 15);
        chk(res_tap[4*l +: 4] == 4'(p % 15), "R6 lane tap (R2 radix)", res_tap[4*l +: 4], p % 15);
      end
      for (int l = 0; l < 8; l++) begin
        int eo = (ec[l] == 0) ? 0 : ((ec[l] - mn) & 3);
        chk(coarse_ofs[2*l +: 2] == 2'(eo), "R7 coarse offset", coarse_ofs[2*l +: 2], eo);
      end
      chk(dly_coarse == 4'(mn), "R7 shared coarse is minimum", dly_coarse, mn);
      chk(dly_pi == 3'd7, "R6 final PI code", dly_pi, 7);
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
    chk(fail == exp_fail, "R10 fail sticky after done", fail, exp_fail);
    chk(proto_bad == 0, "R4 probe reset/read sequence", proto_bad, 0);
    chk(rcv_bad == 0, "R5 enable matches active lane", rcv_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(done == 0 && fail == 0 && rd_req == 0 && rcv_en == 0 && probe_rst_n == 1,
        "R1 reset state", {done, fail, rd_req, rcv_en, probe_rst_n}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int l = 0; l < 8; l++) edge_pos[l] = 300;
    run_cal(4, 1'b0, 0);

    edge_pos = '{61, 75, 76, 120, 135, 150, 239, 181};
    run_cal(2, 1'b0, 0);

    edge_pos = '{110, 95, 130, 50, 160, 200, 171, 90};
    run_cal(3, 1'b0, 0);

    for (int r = 0; r < 4; r++) begin
      for (int l = 0; l < 8; l++) edge_pos[l] = 60 + int'($urandom_range(640));
      run_cal(2 + int'($urandom_range(4)), 1'b0, 0);
    end

    for (int l = 0; l < 8; l++) edge_pos[l] = 300;
    edge_pos[5] = 5000;
    run_cal(4, 1'b1, 5);

    for (int l = 0; l < 8; l++) edge_pos[l] = 240 + 7 * l;
    run_cal(4, 1'b0, 0);

    for (int l = 0; l < 8; l++) edge_pos[l] = 300;
    edge_pos[2] = 20;
    run_cal(4, 1'b1, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule